// File: doc/BRIEF.md
# Level and Edge Trigger Unit

This block watches a parallel stream of logic samples, one word for each cycle in which the sample enable is high. It raises a single-cycle trigger pulse when the configured condition is met. The condition has two parts. The first is a level pattern that can cover any subset of channels. The second is an optional edge on one chosen channel. When both parts are enabled, they must be satisfied by the same sample.

The configuration is presented on plain register inputs: a level mask, a level value, an edge enable, an edge channel index and an edge polarity code. An arm pulse starts a watch. After the unit fires, a latched trigger flag stays high and further matches are ignored until the next arm pulse.

The compare path is one level of logic feeding registers. This keeps it usable at the full sample rate.

Top module: `lvl_edge_trigger`

## Requirements
- R1: After reset, `trig_pulse` and `triggered` are 0, and the unit stays idle until `arm` is pulsed. Samples taken while idle never cause a pulse.
- R2: A channel takes part in the level condition when its `lvl_mask` bit is 1. The level condition holds when every such channel equals the matching `lvl_value` bit. Channels whose mask bit is 0 are ignored.
- R3: With `lvl_mask` all zero and `edge_en` low, the unit fires on the first enabled sample after arming.
- R4: The edge condition looks only at channel `edge_sel`. Transitions on any other channel do not satisfy it.
- R5: The `edge_pol` code selects the edge type: 0 is rising (previous 0, current 1), 1 is falling (previous 1, current 0), and 2 or 3 is either direction.
- R6: When `edge_en` is high, a pulse requires the edge and the level condition to hold in the same sample.
- R7: An edge is judged against the previous enabled sample taken since arming. The first enabled sample after arming never satisfies the edge condition.
- R8: `trig_pulse` is high for exactly one cycle. That cycle is the one after the clock edge that captured the matching sample.
- R9: `triggered` goes high together with the pulse and stays high until the next `arm`. No further pulse occurs before that `arm`.
- R10: A cycle with `smp_en` low is not a sample. It neither fires the unit nor becomes the previous sample.
- R11: `arm` clears `triggered` and restarts the watch. A sample presented in the same cycle as `arm` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Marks a valid sample in this cycle |
| smp_data | input | NCH | Sample word, one bit per channel |
| lvl_mask | input | NCH | Channels taking part in the level condition |
| lvl_value | input | NCH | Required level for each masked channel |
| edge_en | input | 1 | Adds the edge condition |
| edge_sel | input | SW | Index of the edge channel |
| edge_pol | input | 2 | 0 rising, 1 falling, 2/3 either |
| arm | input | 1 | Pulse that starts a new watch |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Latched trigger flag |

## Verification
The bench builds the unit with its default of 16 channels, so the edge index is 4 bits wide. At that width the lowest and highest channels (0 and 15) can both be chosen as the edge channel. The directed cases use both of them, together with mid-range channels, so every index position of the selector is exercised. A long stretch of random samples, sparse masks and random arm pulses is then compared cycle by cycle against a behavioural model. This run reaches re-arming in the middle of a watch, and arm pulses that coincide with samples.

// File: rtl/lvl_edge_trigger.sv
module lvl_edge_trigger #(
  parameter int NCH = 16,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_en,
  input  logic [NCH-1:0] smp_data,
  input  logic [NCH-1:0] lvl_mask,
  input  logic [NCH-1:0] lvl_value,
  input  logic           edge_en,
  input  logic [SW-1:0]  edge_sel,
  input  logic [1:0]     edge_pol,
  input  logic           arm,
  output logic           trig_pulse,
  output logic           triggered
);

  localparam logic [1:0] POL_RISE = 2'd0;
  localparam logic [1:0] POL_FALL = 2'd1;

  logic           armed;
  logic           have_prev;
  logic [NCH-1:0] prev_q;
  logic           edge_ok;

  wire take   = armed & smp_en & ~arm;
  wire lvl_ok = ((smp_data ^ lvl_value) & lvl_mask) == '0;
  wire cur_b  = smp_data[edge_sel];
  wire prv_b  = prev_q[edge_sel];

  always_comb begin
    case (edge_pol)
      POL_RISE: edge_ok = ~prv_b & cur_b;
      POL_FALL: edge_ok = prv_b & ~cur_b;
      default:  edge_ok = prv_b ^ cur_b;
    endcase
  end

  wire hit = take & lvl_ok & (~edge_en | (have_prev & edge_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      have_prev  <= 1'b0;
      prev_q     <= '0;
      trig_pulse <= 1'b0;
      triggered  <= 1'b0;
    end else begin
      trig_pulse <= hit;
      if (arm) begin
        armed     <= 1'b1;
        have_prev <= 1'b0;
        triggered <= 1'b0;
      end else if (take) begin
        prev_q    <= smp_data;
        have_prev <= 1'b1;
        if (hit) begin
          armed     <= 1'b0;
          triggered <= 1'b1;
        end
      end
    end
  end

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  p_pulse_needs_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(smp_en) && !$past(arm));

  p_pulse_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> triggered);

  p_latch_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    triggered && !arm |=> triggered && !trig_pulse);

  p_arm_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !triggered && !trig_pulse);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !arm |=> !trig_pulse);

  p_edge_needs_prev_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse && $past(edge_en) |-> $past(have_prev));

endmodule

// File: tb/lvl_edge_trigger_bench.sv
module lvl_edge_trigger_bench;
  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0;
  logic [NCH-1:0] smp_data = '0;
  logic [NCH-1:0] lvl_mask = '0;
  logic [NCH-1:0] lvl_value = '0;
  logic edge_en = 1'b0;
  logic [3:0] edge_sel = '0;
  logic [1:0] edge_pol = '0;
  logic arm = 1'b0;
  logic trig_pulse, triggered;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  lvl_edge_trigger #(.NCH(NCH)) u_lvl_edge_trigger (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_data(smp_data),
    .lvl_mask(lvl_mask), .lvl_value(lvl_value), .edge_en(edge_en),
    .edge_sel(edge_sel), .edge_pol(edge_pol), .arm(arm),
    .trig_pulse(trig_pulse), .triggered(triggered));

  // behavioural reference model
  bit m_armed, m_have, m_pulse, m_trig;
  bit [NCH-1:0] m_prev;
  always @(posedge clk) begin
    bit lvl, e, pr, cu;
    if (!rst_n) begin
      m_armed = 0; m_have = 0; m_pulse = 0; m_trig = 0; m_prev = '0;
    end else begin
      m_pulse = 0;
      if (arm) begin
        m_armed = 1; m_have = 0; m_trig = 0;
      end else if (m_armed && smp_en) begin
        lvl = 1;
        for (int i = 0; i < NCH; i++)
          if (lvl_mask[i] && smp_data[i] != lvl_value[i]) lvl = 0;
        pr = m_prev[edge_sel];
        cu = smp_data[edge_sel];
        if (edge_pol == 2'd0) e = (pr == 0 && cu == 1);
        else if (edge_pol == 2'd1) e = (pr == 1 && cu == 0);
        else e = (pr != cu);
        if (lvl && (!edge_en || (m_have && e))) begin
          m_pulse = 1; m_trig = 1; m_armed = 0;
        end
        m_prev = smp_data;
        m_have = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks += 2;
      if (trig_pulse !== m_pulse) begin
        errors++;
        $display("FAIL R8 model pulse: actual=%b expected=%b", trig_pulse, m_pulse);
      end
      if (triggered !== m_trig) begin
        errors++;
        $display("FAIL R9 model latch: actual=%b expected=%b", triggered, m_trig);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic en, input logic [NCH-1:0] d);
    @(negedge clk);
    arm = a; smp_en = en; smp_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic smp(input logic [NCH-1:0] d, input logic exp, input string tag);
    step(1'b0, 1'b1, d);
    check(tag, trig_pulse, exp);
  endtask

  task automatic do_arm();
    step(1'b1, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pulse", trig_pulse, 1'b0);
    check("R1 reset latch", triggered, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: idle, samples with trivially true condition do nothing
    smp(16'hFFFF, 1'b0, "R1 idle sample");
    smp(16'h0000, 1'b0, "R1 idle sample 2");

    // R3: empty condition fires on first sample; R10 enable low ignored
    do_arm();
    step(1'b0, 1'b0, 16'h1234);
    check("R10 no enable no pulse", trig_pulse, 1'b0);
    smp(16'h1234, 1'b1, "R3 immediate fire");
    step(1'b0, 1'b0, '0);
    check("R8 pulse drops", trig_pulse, 1'b0);
    check("R9 latch set", triggered, 1'b1);
    smp(16'h1234, 1'b0, "R9 no refire");
    check("R9 latch held", triggered, 1'b1);

    // R2: level condition on a subset
    lvl_mask = 16'h00F0; lvl_value = 16'h0050;
    do_arm();
    check("R11 arm clears latch", triggered, 1'b0);
    smp(16'h0A40, 1'b0, "R2 level mismatch");
    smp(16'hFF5F, 1'b1, "R2 level match, others ignored");

    // R4/R5/R7: rising on channel 15
    lvl_mask = '0; edge_en = 1'b1; edge_sel = 4'd15; edge_pol = 2'd0;
    do_arm();
    smp(16'h8000, 1'b0, "R7 first sample no edge");
    smp(16'h0000, 1'b0, "R5 falling ignored by rising");
    smp(16'h7FFF, 1'b0, "R4 other channels rise");
    smp(16'h8000, 1'b1, "R5 rising fires");

    // R5 falling on channel 0
    edge_sel = 4'd0; edge_pol = 2'd1;
    do_arm();
    smp(16'h0001, 1'b0, "R7 first sample");
    smp(16'h0001, 1'b0, "R5 steady high");
    step(1'b0, 1'b0, 16'h0000);
    check("R10 disabled cycle", trig_pulse, 1'b0);
    smp(16'h0000, 1'b1, "R5 falling fires");

    // R5 either
    edge_sel = 4'd3; edge_pol = 2'd2;
    do_arm();
    smp(16'h0000, 1'b0, "R7 first sample");
    smp(16'h0008, 1'b1, "R5 either rising");
    edge_pol = 2'd3;
    do_arm();
    smp(16'h0008, 1'b0, "R7 first after rearm");
    smp(16'h0000, 1'b1, "R5 either falling");

    // R6 edge AND level
    lvl_mask = 16'h0003; lvl_value = 16'h0001; edge_sel = 4'd4; edge_pol = 2'd0;
    do_arm();
    smp(16'h0000, 1'b0, "R6 setup");
    smp(16'h0010, 1'b0, "R6 edge without level");
    smp(16'h0001, 1'b0, "R6 level without edge");
    smp(16'h0011, 1'b1, "R6 edge with level");

    // R11 arm together with a sample
    lvl_mask = '0; edge_sel = 4'd2; edge_pol = 2'd0;
    do_arm();
    smp(16'h0000, 1'b0, "R11 setup");
    step(1'b1, 1'b1, 16'h0004);
    check("R11 arm cycle no pulse", trig_pulse, 1'b0);
    smp(16'h0004, 1'b0, "R11 arm sample discarded");
    smp(16'h0000, 1'b0, "R11 falling");
    smp(16'h0004, 1'b1, "R11 rising fires");

    // random stretch against the model
    for (int n = 0; n < 2000; n++) begin
      if ($urandom_range(0, 49) == 0) begin
        lvl_mask = $urandom() & $urandom() & $urandom();
        lvl_value = $urandom();
        edge_en = $urandom_range(0, 1);
        edge_sel = $urandom_range(0, 15);
        edge_pol = $urandom_range(0, 3);
      end
      step($urandom_range(0, 19) == 0, $urandom_range(0, 3) != 0, $urandom());
    end

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule